// File: doc/BRIEF.md
# Full/Empty Tagged Register File

A register file in which every 64-bit word carries a one-bit presence tag that reads FULL or EMPTY. Each access can be made conditional on that tag. A consumer read can wait until a word is FULL and can drain it to EMPTY. A producer write can insist that the slot is EMPTY. Any write that completes fills the word. The file therefore works as a fine-grained producer/consumer synchroniser and not only as storage. One operation has two read ports and one write port. Each port has an address, an optional indexing bit that adds the current context's index register, condition flags, and a done or retry reply. The reply appears one clock after the request. The three ports of one operation succeed or fail together.

The upper part of the address space, from `CONST_BASE` upward, holds constants and has no tag. A side port preloads any word and marks it FULL. A second side port loads the per-context index registers. After reset the block walks every address once to clear data and tags. The control FSM has two states, `ST_CLEAR` and `ST_RUN`. Reset enters `ST_CLEAR`. The sweep counter reaching the last address moves the FSM from `ST_CLEAR` to `ST_RUN`. `ST_RUN` holds until the next reset.

Top module: `fe_regfile`

## Requirements
- R1: After reset the block stays in `ST_CLEAR` for exactly 2^ADDR_W cycles, with `ready` low, and every enabled port replies retry. After that, `ready` stays high, every word reads zero, and every tagged word is EMPTY.
- R2: A read with neither `wait` nor `unset` set always completes, returns the word and leaves the tag unchanged.
- R3: A read with `wait` set completes only when the addressed word is FULL. Otherwise it replies retry.
- R4: A completed read with `unset` set leaves the word EMPTY, with or without `wait`. Setting both flags gives a take: wait for FULL, then drain.
- R5: A write with `need_empty` set stores only when the target word is EMPTY.
- R6: Every completed write leaves its word FULL, whatever flags it carried.
- R7: With the port's `idx` bit set, the effective address is (address + index register of `ctx_sel`) modulo 2^ADDR_W. An index load on the index port takes effect from the next cycle.
- R8: Words at addresses >= CONST_BASE have no tag. On them, reads never wait, `unset` changes nothing, and writes complete regardless of `need_empty`.
- R9: An operation is atomic. If any enabled port's condition fails, every enabled port replies retry, no word or tag changes, and `ra_data`/`rb_data` keep their previous values.
- R10: A read and a write to the same word in one operation are resolved read-first: the read returns the old data. The final tag is FULL even when the read drains.
- R11: The init port writes its word and marks it FULL in `ST_RUN`, and is ignored in `ST_CLEAR`. On the same address as a completing write in the same cycle, the init data wins.
- R12: Replies are registered and appear in the cycle after the request. A port that is not enabled gets neither done nor retry. Done and retry are never both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctx_sel | input | CTX_W | Context whose index register the operation uses |
| ix_ld | input | 1 | Load an index register |
| ix_ld_ctx | input | CTX_W | Context whose index register is loaded |
| ix_ld_val | input | ADDR_W | Index value to load |
| init_en | input | 1 | Preload request |
| init_addr | input | ADDR_W | Preload address (never indexed) |
| init_data | input | DATA_W | Preload data |
| ra_en | input | 1 | Read port A enable |
| ra_addr | input | ADDR_W | Read port A address |
| ra_idx | input | 1 | Read port A adds the index register |
| ra_wait | input | 1 | Read port A waits for FULL |
| ra_unset | input | 1 | Read port A drains to EMPTY |
| ra_data | output | DATA_W | Read port A data, updated only on done |
| ra_done | output | 1 | Read port A completed |
| ra_retry | output | 1 | Read port A must be retried |
| rb_en | input | 1 | Read port B enable |
| rb_addr | input | ADDR_W | Read port B address |
| rb_idx | input | 1 | Read port B adds the index register |
| rb_wait | input | 1 | Read port B waits for FULL |
| rb_unset | input | 1 | Read port B drains to EMPTY |
| rb_data | output | DATA_W | Read port B data, updated only on done |
| rb_done | output | 1 | Read port B completed |
| rb_retry | output | 1 | Read port B must be retried |
| w_en | input | 1 | Write port enable |
| w_addr | input | ADDR_W | Write port address |
| w_idx | input | 1 | Write port adds the index register |
| w_need_empty | input | 1 | Write stores only into an EMPTY word |
| w_data | input | DATA_W | Write data |
| w_done | output | 1 | Write completed |
| w_retry | output | 1 | Write must be retried |
| ready | output | 1 | High in `ST_RUN` |

## Verification
Two functions can fall in the same cycle. A draining read and a write can hit the same word, and two ports of one operation can disagree on whether their conditions hold. The bench forces the first case by pairing a take read with a write on one address. It judges the result by the old data on the read port and by a following wait read that completes with the new data. The second case is provoked by pairing a satisfied read with a failing one. A long pseudo-random run mixes both collisions with index loads and preloads against an arithmetic tag and data model. Every reply must match that model cycle for cycle.

// File: rtl/fe_pkg.sv
package fe_pkg;

    typedef enum logic [0:0] {
        ST_CLEAR = 1'b0,
        ST_RUN   = 1'b1
    } fe_state_e;

    typedef struct packed {
        logic en;
        logic indexed;
        logic wait_full;
        logic unset;
    } rd_req_t;

    typedef struct packed {
        logic en;
        logic indexed;
        logic need_empty;
    } wr_req_t;

endpackage

// File: rtl/fe_index_table.sv
module fe_index_table #(
    parameter int NUM_CTX = 4,
    parameter int ADDR_W  = 4,
    localparam int CTX_W  = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_en,
    input  logic [CTX_W-1:0]  ld_ctx,
    input  logic [ADDR_W-1:0] ld_val,
    input  logic [CTX_W-1:0]  sel_ctx,
    output logic [ADDR_W-1:0] ix_out
);

    logic [ADDR_W-1:0] ix_q [NUM_CTX];

    for (genvar c = 0; c < NUM_CTX; c++) begin : g_ctx
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ix_q[c] <= '0;
            end else if (ld_en && (ld_ctx == CTX_W'(c))) begin
                ix_q[c] <= ld_val;
            end
        end
    end

    always_comb begin
        ix_out = '0;
        for (int c = 0; c < NUM_CTX; c++) begin
            if (sel_ctx == CTX_W'(c)) begin
                ix_out = ix_q[c];
            end
        end
    end

endmodule

// File: rtl/fe_addr_gen.sv
module fe_addr_gen #(
    parameter int ADDR_W = 4
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [ADDR_W-1:0] ix,
    input  logic              use_ix,
    output logic [ADDR_W-1:0] ea
);

    // Wraps modulo the address space.
    always_comb begin
        ea = use_ix ? (base + ix) : base;
    end

endmodule

// File: rtl/fe_store.sv
module fe_store #(
    parameter int DATA_W     = 64,
    parameter int ADDR_W     = 4,
    parameter int CONST_BASE = 12,
    parameter int RD_PORTS   = 2,
    localparam int DEPTH     = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              clr_en,
    input  logic [ADDR_W-1:0] clr_addr,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              init_en,
    input  logic [ADDR_W-1:0] init_addr,
    input  logic [DATA_W-1:0] init_data,
    input  logic              un_en   [RD_PORTS],
    input  logic [ADDR_W-1:0] un_addr [RD_PORTS],
    input  logic [ADDR_W-1:0] rd_addr [RD_PORTS],
    output logic [DATA_W-1:0] rd_word [RD_PORTS],
    output logic              rd_tag  [RD_PORTS],
    output logic              wr_tag
);

    logic [DATA_W-1:0] mem_q [DEPTH];
    logic [DEPTH-1:0]  tag_q;
    logic [DEPTH-1:0]  fill_hit;
    logic [DEPTH-1:0]  drain_hit;

    always_comb begin
        fill_hit  = '0;
        drain_hit = '0;
        for (int w = 0; w < DEPTH; w++) begin
            fill_hit[w] = (wr_en && (wr_addr == ADDR_W'(w)))
                        || (init_en && (init_addr == ADDR_W'(w)));
            for (int p = 0; p < RD_PORTS; p++) begin
                if (un_en[p] && (un_addr[p] == ADDR_W'(w))) begin
                    drain_hit[w] = 1'b1;
                end
            end
        end
    end

    // Storage carries no reset: the clear sweep initialises it.
    always_ff @(posedge clk) begin
        for (int w = 0; w < DEPTH; w++) begin
            if (clr_en && (clr_addr == ADDR_W'(w))) begin
                mem_q[w] <= '0;
                tag_q[w] <= (w >= CONST_BASE);
            end else begin
                if (init_en && (init_addr == ADDR_W'(w))) begin
                    mem_q[w] <= init_data;
                end else if (wr_en && (wr_addr == ADDR_W'(w))) begin
                    mem_q[w] <= wr_data;
                end
                if (w >= CONST_BASE) begin
                    tag_q[w] <= 1'b1;
                end else if (fill_hit[w]) begin
                    tag_q[w] <= 1'b1;
                end else if (drain_hit[w]) begin
                    tag_q[w] <= 1'b0;
                end
            end
        end
    end

    for (genvar p = 0; p < RD_PORTS; p++) begin : g_rd
        assign rd_word[p] = mem_q[rd_addr[p]];
        assign rd_tag[p]  = tag_q[rd_addr[p]];
    end

    assign wr_tag = tag_q[wr_addr];

endmodule

// File: rtl/fe_sync_ctrl.sv
module fe_sync_ctrl
    import fe_pkg::*;
#(
    parameter int DATA_W     = 64,
    parameter int ADDR_W     = 4,
    parameter int CONST_BASE = 12,
    parameter int RD_PORTS   = 2,
    localparam int DEPTH     = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  rd_req_t           rd_req  [RD_PORTS],
    input  logic [ADDR_W-1:0] rd_ea   [RD_PORTS],
    input  logic              rd_tag  [RD_PORTS],
    input  logic [DATA_W-1:0] rd_word [RD_PORTS],
    input  wr_req_t           wr_req,
    input  logic [ADDR_W-1:0] wr_ea,
    input  logic              wr_tag,
    input  logic              init_req,
    output logic              clr_en,
    output logic [ADDR_W-1:0] clr_addr,
    output logic              wr_commit,
    output logic              init_commit,
    output logic              un_en      [RD_PORTS],
    output logic              ready,
    output logic [DATA_W-1:0] rd_data_q  [RD_PORTS],
    output logic              rd_done_q  [RD_PORTS],
    output logic              rd_retry_q [RD_PORTS],
    output logic              wr_done_q,
    output logic              wr_retry_q
);

    fe_state_e         state_q;
    fe_state_e         state_d;
    logic [ADDR_W-1:0] cnt_q;
    logic              accept;
    logic              any_en;
    logic              all_ok;
    logic              go;

    function automatic logic is_const(input logic [ADDR_W-1:0] a);
        return (int'(a) >= CONST_BASE);
    endfunction

    // State register and sweep counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_CLEAR;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (clr_en) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_CLEAR: if (cnt_q == ADDR_W'(DEPTH - 1)) state_d = ST_RUN;
            ST_RUN:   state_d = ST_RUN;
            default:  state_d = ST_CLEAR;
        endcase
    end

    // State-decoded outputs
    always_comb begin
        clr_en = 1'b0;
        accept = 1'b0;
        ready  = 1'b0;
        unique case (state_q)
            ST_CLEAR: clr_en = 1'b1;
            ST_RUN: begin
                accept = 1'b1;
                ready  = 1'b1;
            end
            default: clr_en = 1'b1;
        endcase
    end

    assign clr_addr = cnt_q;

    // Condition evaluation against the pre-operation tags
    always_comb begin
        any_en = wr_req.en;
        all_ok = !wr_req.en || is_const(wr_ea) || !wr_req.need_empty || !wr_tag;
        for (int p = 0; p < RD_PORTS; p++) begin
            any_en = any_en || rd_req[p].en;
            if (rd_req[p].en && !is_const(rd_ea[p])
                && rd_req[p].wait_full && !rd_tag[p]) begin
                all_ok = 1'b0;
            end
        end
        go = accept && any_en && all_ok;
        for (int p = 0; p < RD_PORTS; p++) begin
            un_en[p] = go && rd_req[p].en && rd_req[p].unset && !is_const(rd_ea[p]);
        end
    end

    assign wr_commit   = go && wr_req.en;
    assign init_commit = accept && init_req;

    // Registered replies
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int p = 0; p < RD_PORTS; p++) begin
                rd_data_q[p]  <= '0;
                rd_done_q[p]  <= 1'b0;
                rd_retry_q[p] <= 1'b0;
            end
            wr_done_q  <= 1'b0;
            wr_retry_q <= 1'b0;
        end else begin
            for (int p = 0; p < RD_PORTS; p++) begin
                rd_done_q[p]  <= go && rd_req[p].en;
                rd_retry_q[p] <= rd_req[p].en && !go;
                if (go && rd_req[p].en) begin
                    rd_data_q[p] <= rd_word[p];
                end
            end
            wr_done_q  <= go && wr_req.en;
            wr_retry_q <= wr_req.en && !go;
        end
    end

endmodule

// File: rtl/fe_regfile.sv
module fe_regfile
    import fe_pkg::*;
#(
    parameter int DATA_W     = 64,
    parameter int ADDR_W     = 4,
    parameter int NUM_CTX    = 4,
    parameter int CONST_BASE = 12,
    localparam int CTX_W     = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1,
    localparam int RD_PORTS  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CTX_W-1:0]  ctx_sel,
    input  logic              ix_ld,
    input  logic [CTX_W-1:0]  ix_ld_ctx,
    input  logic [ADDR_W-1:0] ix_ld_val,
    input  logic              init_en,
    input  logic [ADDR_W-1:0] init_addr,
    input  logic [DATA_W-1:0] init_data,
    input  logic              ra_en,
    input  logic [ADDR_W-1:0] ra_addr,
    input  logic              ra_idx,
    input  logic              ra_wait,
    input  logic              ra_unset,
    output logic [DATA_W-1:0] ra_data,
    output logic              ra_done,
    output logic              ra_retry,
    input  logic              rb_en,
    input  logic [ADDR_W-1:0] rb_addr,
    input  logic              rb_idx,
    input  logic              rb_wait,
    input  logic              rb_unset,
    output logic [DATA_W-1:0] rb_data,
    output logic              rb_done,
    output logic              rb_retry,
    input  logic              w_en,
    input  logic [ADDR_W-1:0] w_addr,
    input  logic              w_idx,
    input  logic              w_need_empty,
    input  logic [DATA_W-1:0] w_data,
    output logic              w_done,
    output logic              w_retry,
    output logic              ready
);

    rd_req_t           rd_req     [RD_PORTS];
    logic [ADDR_W-1:0] rd_base    [RD_PORTS];
    logic [ADDR_W-1:0] rd_ea      [RD_PORTS];
    logic              rd_tag     [RD_PORTS];
    logic [DATA_W-1:0] rd_word    [RD_PORTS];
    logic              un_en      [RD_PORTS];
    logic [DATA_W-1:0] rd_data_q  [RD_PORTS];
    logic              rd_done_q  [RD_PORTS];
    logic              rd_retry_q [RD_PORTS];
    wr_req_t           wr_req;
    logic [ADDR_W-1:0] wr_ea;
    logic              wr_tag;
    logic [ADDR_W-1:0] cur_ix;
    logic              clr_en;
    logic [ADDR_W-1:0] clr_addr;
    logic              wr_commit;
    logic              init_commit;

    assign rd_req[0]  = '{en: ra_en, indexed: ra_idx, wait_full: ra_wait, unset: ra_unset};
    assign rd_req[1]  = '{en: rb_en, indexed: rb_idx, wait_full: rb_wait, unset: rb_unset};
    assign rd_base[0] = ra_addr;
    assign rd_base[1] = rb_addr;
    assign wr_req     = '{en: w_en, indexed: w_idx, need_empty: w_need_empty};

    fe_index_table #(
        .NUM_CTX (NUM_CTX),
        .ADDR_W  (ADDR_W)
    ) u_ixtab (
        .clk     (clk),
        .rst_n   (rst_n),
        .ld_en   (ix_ld),
        .ld_ctx  (ix_ld_ctx),
        .ld_val  (ix_ld_val),
        .sel_ctx (ctx_sel),
        .ix_out  (cur_ix)
    );

    for (genvar p = 0; p < RD_PORTS; p++) begin : g_rd_ag
        fe_addr_gen #(.ADDR_W(ADDR_W)) u_ag (
            .base   (rd_base[p]),
            .ix     (cur_ix),
            .use_ix (rd_req[p].indexed),
            .ea     (rd_ea[p])
        );
    end

    fe_addr_gen #(.ADDR_W(ADDR_W)) u_wr_ag (
        .base   (w_addr),
        .ix     (cur_ix),
        .use_ix (wr_req.indexed),
        .ea     (wr_ea)
    );

    fe_store #(
        .DATA_W     (DATA_W),
        .ADDR_W     (ADDR_W),
        .CONST_BASE (CONST_BASE),
        .RD_PORTS   (RD_PORTS)
    ) u_store (
        .clk       (clk),
        .clr_en    (clr_en),
        .clr_addr  (clr_addr),
        .wr_en     (wr_commit),
        .wr_addr   (wr_ea),
        .wr_data   (w_data),
        .init_en   (init_commit),
        .init_addr (init_addr),
        .init_data (init_data),
        .un_en     (un_en),
        .un_addr   (rd_ea),
        .rd_addr   (rd_ea),
        .rd_word   (rd_word),
        .rd_tag    (rd_tag),
        .wr_tag    (wr_tag)
    );

    fe_sync_ctrl #(
        .DATA_W     (DATA_W),
        .ADDR_W     (ADDR_W),
        .CONST_BASE (CONST_BASE),
        .RD_PORTS   (RD_PORTS)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .rd_req      (rd_req),
        .rd_ea       (rd_ea),
        .rd_tag      (rd_tag),
        .rd_word     (rd_word),
        .wr_req      (wr_req),
        .wr_ea       (wr_ea),
        .wr_tag      (wr_tag),
        .init_req    (init_en),
        .clr_en      (clr_en),
        .clr_addr    (clr_addr),
        .wr_commit   (wr_commit),
        .init_commit (init_commit),
        .un_en       (un_en),
        .ready       (ready),
        .rd_data_q   (rd_data_q),
        .rd_done_q   (rd_done_q),
        .rd_retry_q  (rd_retry_q),
        .wr_done_q   (w_done),
        .wr_retry_q  (w_retry)
    );

    assign ra_data  = rd_data_q[0];
    assign ra_done  = rd_done_q[0];
    assign ra_retry = rd_retry_q[0];
    assign rb_data  = rd_data_q[1];
    assign rb_done  = rd_done_q[1];
    assign rb_retry = rd_retry_q[1];

endmodule

// File: rtl/fe_regfile_chk.sv
module fe_regfile_chk #(
    parameter int DATA_W     = 64,
    parameter int ADDR_W     = 4,
    parameter int NUM_CTX    = 4,
    parameter int CONST_BASE = 12,
    localparam int CTX_W     = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic [CTX_W-1:0]  ctx_sel,
    input logic              ix_ld,
    input logic [CTX_W-1:0]  ix_ld_ctx,
    input logic [ADDR_W-1:0] ix_ld_val,
    input logic              init_en,
    input logic [ADDR_W-1:0] init_addr,
    input logic [DATA_W-1:0] init_data,
    input logic              ra_en,
    input logic [ADDR_W-1:0] ra_addr,
    input logic              ra_idx,
    input logic              ra_wait,
    input logic              ra_unset,
    input logic [DATA_W-1:0] ra_data,
    input logic              ra_done,
    input logic              ra_retry,
    input logic              rb_en,
    input logic [ADDR_W-1:0] rb_addr,
    input logic              rb_idx,
    input logic              rb_wait,
    input logic              rb_unset,
    input logic [DATA_W-1:0] rb_data,
    input logic              rb_done,
    input logic              rb_retry,
    input logic              w_en,
    input logic [ADDR_W-1:0] w_addr,
    input logic              w_idx,
    input logic              w_need_empty,
    input logic [DATA_W-1:0] w_data,
    input logic              w_done,
    input logic              w_retry,
    input logic              ready
);

    AST_REPLY_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(ra_done && ra_retry) && !(rb_done && rb_retry) && !(w_done && w_retry)); // R12

    AST_REPLY_A: assert property (@(posedge clk) disable iff (!rst_n)
        ra_en |=> (ra_done || ra_retry)); // R12

    AST_SILENT_W: assert property (@(posedge clk) disable iff (!rst_n)
        !w_en |=> (!w_done && !w_retry)); // R12

    AST_ATOMIC_GROUP: assert property (@(posedge clk) disable iff (!rst_n)
        (ra_done || rb_done || w_done) |-> !(ra_retry || rb_retry || w_retry)); // R9

    AST_HOLD_A: assert property (@(posedge clk) disable iff (!rst_n)
        !ra_done |-> $stable(ra_data)); // R9

    AST_HOLD_B: assert property (@(posedge clk) disable iff (!rst_n)
        !rb_done |-> $stable(rb_data)); // R9

    AST_CLEAR_NO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |=> !(ra_done || rb_done || w_done)); // R1

    AST_READY_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> ready); // R1

    AST_CONST_NO_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && ra_en && !ra_idx && (int'(ra_addr) >= CONST_BASE) && !rb_en && !w_en)
        |=> ra_done); // R8

endmodule

bind fe_regfile fe_regfile_chk #(
    .DATA_W     (DATA_W),
    .ADDR_W     (ADDR_W),
    .NUM_CTX    (NUM_CTX),
    .CONST_BASE (CONST_BASE)
) u_chk (.*);

// File: tb/fe_regfile_tb.sv
module fe_regfile_tb;

    localparam int DW = 64;
    localparam int AW = 4;
    localparam int NC = 4;
    localparam int CB = 12;
    localparam int DEP = 1 << AW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0] ctx_sel = '0;
    logic ix_ld = 1'b0;
    logic [1:0] ix_ld_ctx = '0;
    logic [AW-1:0] ix_ld_val = '0;
    logic init_en = 1'b0;
    logic [AW-1:0] init_addr = '0;
    logic [DW-1:0] init_data = '0;
    logic ra_en = 1'b0, ra_idx = 1'b0, ra_wait = 1'b0, ra_unset = 1'b0;
    logic [AW-1:0] ra_addr = '0;
    logic [DW-1:0] ra_data;
    logic ra_done, ra_retry;
    logic rb_en = 1'b0, rb_idx = 1'b0, rb_wait = 1'b0, rb_unset = 1'b0;
    logic [AW-1:0] rb_addr = '0;
    logic [DW-1:0] rb_data;
    logic rb_done, rb_retry;
    logic w_en = 1'b0, w_idx = 1'b0, w_need_empty = 1'b0;
    logic [AW-1:0] w_addr = '0;
    logic [DW-1:0] w_data = '0;
    logic w_done, w_retry;
    logic ready;

    always #2 clk = ~clk;

    fe_regfile #(.DATA_W(DW), .ADDR_W(AW), .NUM_CTX(NC), .CONST_BASE(CB)) u_dut (
        .clk(clk), .rst_n(rst_n), .ctx_sel(ctx_sel), .ix_ld(ix_ld),
        .ix_ld_ctx(ix_ld_ctx), .ix_ld_val(ix_ld_val), .init_en(init_en),
        .init_addr(init_addr), .init_data(init_data),
        .ra_en(ra_en), .ra_addr(ra_addr), .ra_idx(ra_idx), .ra_wait(ra_wait),
        .ra_unset(ra_unset), .ra_data(ra_data), .ra_done(ra_done), .ra_retry(ra_retry),
        .rb_en(rb_en), .rb_addr(rb_addr), .rb_idx(rb_idx), .rb_wait(rb_wait),
        .rb_unset(rb_unset), .rb_data(rb_data), .rb_done(rb_done), .rb_retry(rb_retry),
        .w_en(w_en), .w_addr(w_addr), .w_idx(w_idx), .w_need_empty(w_need_empty),
        .w_data(w_data), .w_done(w_done), .w_retry(w_retry), .ready(ready)
    );

    typedef struct {
        logic [1:0]    ctx;
        logic          a_en, a_ix, a_wait, a_unset;
        logic [AW-1:0] a_addr;
        logic          b_en, b_ix, b_wait, b_unset;
        logic [AW-1:0] b_addr;
        logic          w_en, w_ix, w_need;
        logic [AW-1:0] w_addr;
        logic [DW-1:0] w_data;
        logic          i_en;
        logic [AW-1:0] i_addr;
        logic [DW-1:0] i_data;
        logic          x_en;
        logic [1:0]    x_ctx;
        logic [AW-1:0] x_val;
    } op_t;

    // Bench model
    logic [DW-1:0] mdata [DEP];
    logic          mtag  [DEP];
    logic [AW-1:0] mix   [NC];
    logic [DW-1:0] exp_a = '0;
    logic [DW-1:0] exp_b = '0;

    int n_checks = 0;
    int n_fail = 0;
    bit done_flag = 0;
    logic [31:0] seed = 32'h1234_5678;

    function automatic op_t blank();
        op_t o;
        o = '{default: '0};
        return o;
    endfunction

    function automatic logic [AW-1:0] eff(input logic [AW-1:0] a, input logic ix,
                                          input logic [1:0] c);
        return ix ? AW'(a + mix[c]) : a;
    endfunction

    function automatic logic [31:0] rnd();
        seed = seed ^ (seed << 13);
        seed = seed ^ (seed >> 17);
        seed = seed ^ (seed << 5);
        return seed;
    endfunction

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1;
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    endtask

    task automatic check_val(input string req, input logic [DW-1:0] got,
                             input logic [DW-1:0] expv);
        n_checks++;
        if (got !== expv) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, expv);
        end
    endtask

    // Drive at a falling edge, sample at the next falling edge (R12: one clock later)
    task automatic run_op(input op_t o, input string req);
        logic [AW-1:0] ea_a, ea_b, ea_w;
        logic ok_a, ok_b, ok_w, go;
        logic [5:0] exp_flags, got_flags;
        ctx_sel = o.ctx;
        ra_en = o.a_en; ra_idx = o.a_ix; ra_wait = o.a_wait; ra_unset = o.a_unset; ra_addr = o.a_addr;
        rb_en = o.b_en; rb_idx = o.b_ix; rb_wait = o.b_wait; rb_unset = o.b_unset; rb_addr = o.b_addr;
        w_en = o.w_en; w_idx = o.w_ix; w_need_empty = o.w_need; w_addr = o.w_addr; w_data = o.w_data;
        init_en = o.i_en; init_addr = o.i_addr; init_data = o.i_data;
        ix_ld = o.x_en; ix_ld_ctx = o.x_ctx; ix_ld_val = o.x_val;
        ea_a = eff(o.a_addr, o.a_ix, o.ctx);
        ea_b = eff(o.b_addr, o.b_ix, o.ctx);
        ea_w = eff(o.w_addr, o.w_ix, o.ctx);
        ok_a = !o.a_en || (ea_a >= CB) || !o.a_wait || mtag[ea_a];
        ok_b = !o.b_en || (ea_b >= CB) || !o.b_wait || mtag[ea_b];
        ok_w = !o.w_en || (ea_w >= CB) || !o.w_need || !mtag[ea_w];
        go = (o.a_en || o.b_en || o.w_en) && ok_a && ok_b && ok_w;
        exp_flags = {go && o.a_en, o.a_en && !go, go && o.b_en, o.b_en && !go,
                     go && o.w_en, o.w_en && !go};
        if (go && o.a_en) exp_a = mdata[ea_a];
        if (go && o.b_en) exp_b = mdata[ea_b];
        @(negedge clk);
        got_flags = {ra_done, ra_retry, rb_done, rb_retry, w_done, w_retry};
        n_checks++;
        if (got_flags !== exp_flags || ra_data !== exp_a || rb_data !== exp_b) begin
            n_fail++;
            $display("FAIL %s: flags %b data %h/%h expected flags %b data %h/%h",
                     req, got_flags, ra_data, rb_data, exp_flags, exp_a, exp_b);
        end
        if (go) begin
            if (o.a_en && o.a_unset && ea_a < CB) mtag[ea_a] = 1'b0;
            if (o.b_en && o.b_unset && ea_b < CB) mtag[ea_b] = 1'b0;
            if (o.w_en) begin mdata[ea_w] = o.w_data; mtag[ea_w] = 1'b1; end
        end
        if (o.i_en) begin mdata[o.i_addr] = o.i_data; mtag[o.i_addr] = 1'b1; end
        if (o.x_en) mix[o.x_ctx] = o.x_val;
    endtask

    task automatic idle();
        ra_en = 0; rb_en = 0; w_en = 0; init_en = 0; ix_ld = 0;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got hung run expected completion");
        finish_run();
    end

    initial begin : main
        op_t o;
        int cyc;
        for (int i = 0; i < DEP; i++) begin mdata[i] = '0; mtag[i] = 1'b0; end
        for (int i = 0; i < NC; i++) mix[i] = '0;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: an op during the sweep is retried; count cycles to ready
        ra_en = 1'b1; ra_addr = 4'd0;
        init_en = 1'b1; init_addr = 4'd1; init_data = 64'hDEAD;
        @(negedge clk);
        check_val("R1 retry in clear", {62'd0, ra_done, ra_retry}, 64'd1);
        check_val("R1 ready low", {63'd0, ready}, 64'd0);
        idle();
        cyc = 1;
        while (!ready && cyc < 100) begin @(negedge clk); cyc++; end
        check_val("R1 sweep length", 64'(cyc), 64'(DEP));

        // R1: all words zero, R11: init during clear ignored (addr 1 stays zero/EMPTY)
        for (int a = 0; a < DEP; a++) begin
            o = blank(); o.a_en = 1; o.a_addr = AW'(a);
            run_op(o, "R1 zero after clear");
        end
        o = blank(); o.a_en = 1; o.a_wait = 1; o.a_addr = 4'd1;
        run_op(o, "R1 empty after clear");
        check_val("R1 wait retry on empty", {63'd0, ra_retry}, 64'd1);

        // R11: preload marks FULL
        o = blank(); o.i_en = 1; o.i_addr = 4'd3; o.i_data = 64'h0123_4567_89AB_CDEF;
        run_op(o, "R11 init");
        o = blank(); o.a_en = 1; o.a_wait = 1; o.a_addr = 4'd3;
        run_op(o, "R11 init then wait read");
        check_val("R11 init data", ra_data, 64'h0123_4567_89AB_CDEF);

        // R2: plain reads leave the tag alone; R3 wait read sees it still FULL
        o = blank(); o.b_en = 1; o.b_addr = 4'd3;
        run_op(o, "R2 plain read");
        o = blank(); o.a_en = 1; o.a_wait = 1; o.a_addr = 4'd3;
        run_op(o, "R3 wait read on full");
        check_val("R3 done", {63'd0, ra_done}, 64'd1);

        // R4: unset-only drains; then wait read retries
        o = blank(); o.a_en = 1; o.a_unset = 1; o.a_addr = 4'd3;
        run_op(o, "R4 unset read");
        o = blank(); o.a_en = 1; o.a_wait = 1; o.a_addr = 4'd3;
        run_op(o, "R4 drained word");
        check_val("R4 retry after drain", {63'd0, ra_retry}, 64'd1);

        // R5/R6: need-empty write into EMPTY fills; second one retries
        o = blank(); o.w_en = 1; o.w_need = 1; o.w_addr = 4'd3; o.w_data = 64'hAAAA_0000_0000_0003;
        run_op(o, "R5 write into empty");
        check_val("R5 done", {63'd0, w_done}, 64'd1);
        o = blank(); o.w_en = 1; o.w_need = 1; o.w_addr = 4'd3; o.w_data = 64'hBBBB;
        run_op(o, "R5 write into full");
        check_val("R5 retry", {63'd0, w_retry}, 64'd1);
        o = blank(); o.a_en = 1; o.a_wait = 1; o.a_unset = 1; o.a_addr = 4'd3;
        run_op(o, "R4 take");
        check_val("R6 data kept", ra_data, 64'hAAAA_0000_0000_0003);
        o = blank(); o.w_en = 1; o.w_addr = 4'd3; o.w_data = 64'h6666;
        run_op(o, "R6 plain write fills");
        o = blank(); o.a_en = 1; o.a_wait = 1; o.a_addr = 4'd3;
        run_op(o, "R6 full after write");

        // R10: take and write on one word in one operation
        o = blank(); o.i_en = 1; o.i_addr = 4'd5; o.i_data = 64'h5555;
        run_op(o, "R11 init 5");
        o = blank(); o.a_en = 1; o.a_wait = 1; o.a_unset = 1; o.a_addr = 4'd5;
        o.w_en = 1; o.w_addr = 4'd5; o.w_data = 64'h5A5A;
        run_op(o, "R10 collide");
        check_val("R10 old data", ra_data, 64'h5555);
        o = blank(); o.a_en = 1; o.a_wait = 1; o.a_addr = 4'd5;
        run_op(o, "R10 final full");
        check_val("R10 new data", ra_data, 64'h5A5A);

        // R7: indexed access through context 2
        o = blank(); o.x_en = 1; o.x_ctx = 2'd2; o.x_val = 4'd5;
        o.a_en = 1; o.a_ix = 1; o.a_addr = 4'd14; o.ctx = 2'd2;
        run_op(o, "R7 load same cycle uses old index");
        o = blank(); o.a_en = 1; o.a_ix = 1; o.a_addr = 4'd14; o.ctx = 2'd2; o.a_wait = 1;
        run_op(o, "R7 indexed wrap");
        check_val("R7 ea 3", ra_data, 64'h6666);

        // R8: constant region
        o = blank(); o.a_en = 1; o.a_wait = 1; o.a_unset = 1; o.a_addr = 4'd13;
        run_op(o, "R8 const wait");
        check_val("R8 const done", {63'd0, ra_done}, 64'd1);
        o = blank(); o.a_en = 1; o.a_wait = 1; o.a_addr = 4'd13;
        run_op(o, "R8 const unset no effect");
        o = blank(); o.w_en = 1; o.w_need = 1; o.w_addr = 4'd13; o.w_data = 64'h1313;
        run_op(o, "R8 const write");
        o = blank(); o.w_en = 1; o.w_need = 1; o.w_addr = 4'd13; o.w_data = 64'h3131;
        run_op(o, "R8 const write ignores need_empty");
        check_val("R8 const done", {63'd0, w_done}, 64'd1);

        // R9: one failing port blocks the whole operation
        o = blank(); o.a_en = 1; o.a_wait = 1; o.a_unset = 1; o.a_addr = 4'd3;
        o.b_en = 1; o.b_wait = 1; o.b_addr = 4'd7;
        o.w_en = 1; o.w_addr = 4'd8; o.w_data = 64'h8888;
        run_op(o, "R9 atomic retry");
        check_val("R9 all retry", {61'd0, ra_retry, rb_retry, w_retry}, 64'd7);
        o = blank(); o.a_en = 1; o.a_wait = 1; o.a_addr = 4'd3; o.b_en = 1; o.b_addr = 4'd8;
        run_op(o, "R9 no side effects");

        // R11: init beats a write on the same word
        o = blank(); o.i_en = 1; o.i_addr = 4'd9; o.i_data = 64'h9191;
        o.w_en = 1; o.w_addr = 4'd9; o.w_data = 64'h9999;
        run_op(o, "R11 init vs write");
        o = blank(); o.a_en = 1; o.a_wait = 1; o.a_addr = 4'd9;
        run_op(o, "R11 init wins");
        check_val("R11 init data wins", ra_data, 64'h9191);

        // Mixed sweep of flags, addresses, contexts, preloads and index loads
        for (int n = 0; n < 3000; n++) begin
            logic [31:0] r1, r2;
            r1 = rnd(); r2 = rnd();
            o = blank();
            o.ctx = r2[8:7];
            o.a_en = r1[0] | r1[1]; o.a_ix = r1[2] & r1[3]; o.a_wait = r1[4];
            o.a_unset = r1[5]; o.a_addr = r1[9:6];
            o.b_en = r1[10] & r1[11]; o.b_ix = r1[12] & r1[13]; o.b_wait = r1[14];
            o.b_unset = r1[15]; o.b_addr = r1[19:16];
            o.w_en = r1[20] | r1[21]; o.w_ix = r1[22] & r1[23]; o.w_need = r1[24];
            o.w_addr = r1[28:25]; o.w_data = {rnd(), rnd()};
            o.i_en = r2[0] & r2[1] & r2[2]; o.i_addr = r2[12:9]; o.i_data = {rnd(), r2};
            o.x_en = r2[3] & r2[4] & r2[5] & r2[6]; o.x_ctx = r2[14:13]; o.x_val = r2[18:15];
            run_op(o, "R9 sweep");
        end

        idle();
        @(negedge clk);
        finish_run();
    end

endmodule